// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block serves one bank of up to 32 general-purpose pins. Each pin has an output latch and a direction bit that decide whether the block drives it. Each pin also has an edge or level detector. A single register port gives software access to the latches, the direction bits, an interrupt enable mask, three per-pin sense-select masks and a pending mask. Writing a 1 to a bit of the pending mask clears that bit.

Detection runs on every pin at all times, whatever the pin's direction and whatever its enable bit. A pending bit records each detected condition. The interrupt line is raised while any pin has both its pending bit and its enable bit set. The pin inputs are expected to arrive already synchronised to `clk`. Each register is addressed by a 3-bit word index. Bit n of every register belongs to pin n.

Top module: `gpio_irq_bank`

## Requirements
- R1: While `rst_n` is low, every register clears to zero. After reset `pin_oe` is zero and `irq` is low.
- R2: A write to index 0 loads the output latch, which appears on `pin_out`. A write to index 1 loads the direction mask, which appears on `pin_oe` (1 = driven, 0 = input). Bit n of each register controls pin n.
- R3: Reading index 0 returns, for each pin, the latch bit when its direction bit is 1 and the live `pin_in` bit when it is 0. Reading index 1 returns the direction mask.
- R4: The sense-select masks are at index 3 (sel0), index 4 (sel1) and index 5 (sel2). With sel1=0 and sel2=0, a pin with sel0=0 sets its pending bit on a 1-to-0 input change, and a pin with sel0=1 sets it on a 0-to-1 change. A steady input sets nothing. Each pin uses its own select bits.
- R5: With sel1=0 and sel2=1, a pin sets its pending bit on any input change, whatever the value of sel0.
- R6: With sel1=1, a pin sets its pending bit on every clock edge at which the input equals sel0 (level high for sel0=1, level low for sel0=0). A pending bit that is cleared while the level is still present is set again.
- R7: The pending mask is at index 6. Writing 1 to a bit clears it and writing 0 leaves it unchanged. No other action clears a pending bit.
- R8: When a detected condition and a clearing write hit the same pin in the same cycle, the pending bit ends up set.
- R9: The enable mask is at index 2. With REG_IRQ=0, `irq` equals the OR over all pins of (pending AND enable) in the same cycle. With REG_IRQ=1, `irq` is that value one cycle later. Pending bits are set whatever the enable mask holds.
- R10: Input changes that happen while reset is asserted set no pending bit after reset is released.
- R11: A change detected on the clock edge at which the input first shows a new value is visible in the pending mask straight after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index for both reads and writes |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Read data for `reg_idx` (combinational) |
| pin_in | input | NPIN | Synchronised pin input levels |
| pin_out | output | NPIN | Output latch value |
| pin_oe | output | NPIN | Per-pin output enable (direction mask) |
| irq | output | 1 | Bank interrupt request |

## Verification
The hardest case to reach is a detected condition and a clearing write landing on the same pin in the same clock cycle. The bench gets there by changing the pins and asserting the pending-clear write on the same falling clock edge, so both are seen at the following rising edge. A level-sensed pin cleared while its level persists is a second hard case. The bench sweeps every select combination across pins that see all four (previous, current) input pairs at once, so that case is covered along with steady and changing inputs.

// File: rtl/gib_pkg.sv
package gib_pkg;

   localparam int IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      RI_DATA  = 3'd0,
      RI_DIR   = 3'd1,
      RI_IEN   = 3'd2,
      RI_SEL0  = 3'd3,
      RI_SEL1  = 3'd4,
      RI_SEL2  = 3'd5,
      RI_PEND  = 3'd6,
      RI_SPARE = 3'd7
   } reg_idx_e;

   // Sense decode: sel1 picks level mode; otherwise sel2 picks any-change;
   // otherwise sel0 picks rising (1) or falling (0).
   function automatic logic sense_hit(input logic s0, input logic s1,
                                      input logic s2, input logic prv,
                                      input logic cur);
      if (s1)
         return cur == s0;
      else if (s2)
         return cur != prv;
      else if (s0)
         return cur & ~prv;
      else
         return prv & ~cur;
   endfunction

endpackage

// File: rtl/gib_sense.sv
module gib_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic sel0,
   input  logic sel1,
   input  logic sel2,
   output logic hit
);

   // Tracks the pin through reset as well, so no change seen during reset
   // is reported once reset is released.
   logic prev_q;

   always_ff @(posedge clk) begin
      prev_q <= pin;
   end

   assign hit = gib_pkg::sense_hit(sel0, sel1, sel2, prev_q, pin);

   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel1 && $stable(pin)) |-> !hit)
      else $error("edge mode reported a hit on a steady pin"); // R4

endmodule

// File: rtl/gib_regs.sv
module gib_regs
   import gib_pkg::*;
#(
   parameter int NPIN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [NPIN-1:0]  wdata,
   input  logic [NPIN-1:0]  pin_in,
   input  logic [NPIN-1:0]  set_ev,
   output logic [NPIN-1:0]  rdata,
   output logic [NPIN-1:0]  out_q,
   output logic [NPIN-1:0]  dir_q,
   output logic [NPIN-1:0]  ien_q,
   output logic [NPIN-1:0]  sel0_q,
   output logic [NPIN-1:0]  sel1_q,
   output logic [NPIN-1:0]  sel2_q,
   output logic [NPIN-1:0]  pend_q
);

   reg_idx_e        widx;
   logic [NPIN-1:0] clr_mask;
   logic [NPIN-1:0] data_view;

   assign widx      = reg_idx_e'(idx);
   assign clr_mask  = (wr_en && widx == RI_PEND) ? wdata : '0;
   assign data_view = (dir_q & out_q) | (~dir_q & pin_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         ien_q  <= '0;
         sel0_q <= '0;
         sel1_q <= '0;
         sel2_q <= '0;
         pend_q <= '0;
      end else begin
         if (wr_en) begin
            case (widx)
               RI_DATA: out_q  <= wdata;
               RI_DIR:  dir_q  <= wdata;
               RI_IEN:  ien_q  <= wdata;
               RI_SEL0: sel0_q <= wdata;
               RI_SEL1: sel1_q <= wdata;
               RI_SEL2: sel2_q <= wdata;
               default: ;
            endcase
         end
         // A new event is ORed in after the clear, so it survives the clear.
         pend_q <= (pend_q & ~clr_mask) | set_ev;
      end
   end

   always_comb begin
      case (widx)
         RI_DATA: rdata = data_view;
         RI_DIR:  rdata = dir_q;
         RI_IEN:  rdata = ien_q;
         RI_SEL0: rdata = sel0_q;
         RI_SEL1: rdata = sel1_q;
         RI_SEL2: rdata = sel2_q;
         RI_PEND: rdata = pend_q;
         default: rdata = '0;
      endcase
   end

   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == RI_DIR) |=> (dir_q == $past(wdata)))
      else $error("direction mask did not take the written value"); // R2

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && widx == RI_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)))
      else $error("pending bit dropped without a clearing write"); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_ev) |=> ((pend_q & $past(set_ev)) == $past(set_ev)))
      else $error("detected event not recorded as pending"); // R8

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gib_pkg::*;
#(
   parameter int NPIN    = 32,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [NPIN-1:0]  wdata,
   output logic [NPIN-1:0]  rdata,
   input  logic [NPIN-1:0]  pin_in,
   output logic [NPIN-1:0]  pin_out,
   output logic [NPIN-1:0]  pin_oe,
   output logic             irq
);

   if (NPIN < 1 || NPIN > 32) begin : g_bad_npin
      $error("NPIN must lie between 1 and 32");
   end

   logic [NPIN-1:0] ien_q, sel0_q, sel1_q, sel2_q, pend_q, hit;
   logic            irq_next;

   gib_regs #(.NPIN(NPIN)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .idx    (reg_idx),
      .wdata  (wdata),
      .pin_in (pin_in),
      .set_ev (hit),
      .rdata  (rdata),
      .out_q  (pin_out),
      .dir_q  (pin_oe),
      .ien_q  (ien_q),
      .sel0_q (sel0_q),
      .sel1_q (sel1_q),
      .sel2_q (sel2_q),
      .pend_q (pend_q)
   );

   for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
      gib_sense u_sense (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pin_in[gi]),
         .sel0 (sel0_q[gi]),
         .sel1 (sel1_q[gi]),
         .sel2 (sel2_q[gi]),
         .hit  (hit[gi])
      );
   end

   assign irq_next = |(pend_q & ien_q);

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_next;
      end
      assign irq = irq_q;

      AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(|pend_q))
         else $error("irq raised with nothing pending"); // R9
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ien_q == '0) |-> !irq)
         else $error("irq raised while fully masked"); // R9
   end else begin : g_irq_comb
      assign irq = irq_next;

      AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (|pend_q))
         else $error("irq raised with nothing pending"); // R9
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         (ien_q == '0) |-> !irq)
         else $error("irq raised while fully masked"); // R9
   end

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

   localparam int CLK_P = 10;
   localparam int W     = 8;

   localparam logic [2:0] I_DATA = 3'd0, I_DIR = 3'd1, I_IEN = 3'd2,
      I_S0 = 3'd3, I_S1 = 3'd4, I_S2 = 3'd5, I_PEND = 3'd6, I_SPARE = 3'd7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   reg_idx = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] rdata, pin_out, pin_oe;
   logic         irq;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   gpio_irq_bank #(.NPIN(W), .REG_IRQ(1'b0)) u_gpio_irq_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [2:0] i, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_idx = i; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic get(input logic [2:0] i, output logic [W-1:0] d);
      reg_idx = i;
      #1;
      d = rdata;
   endtask

   // Expected pending bits from the mode table in the requirements.
   function automatic logic [W-1:0] expect_hits(
      input logic [W-1:0] s0, input logic [W-1:0] s1, input logic [W-1:0] s2,
      input logic [W-1:0] p, input logic [W-1:0] c);
      logic [W-1:0] r;
      for (int b = 0; b < W; b++) begin
         case ({s1[b], s2[b]})
            2'b10, 2'b11: r[b] = (c[b] === s0[b]);
            2'b01:        r[b] = (p[b] !== c[b]);
            default:      r[b] = s0[b] ? (!p[b] && c[b]) : (p[b] && !c[b]);
         endcase
      end
      return r;
   endfunction

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [W-1:0] v, e1, e2, e3, s0, s1, s2, lat, pv;
      logic [W-1:0] pa, pb;
      string tag;

      // R10: pins fall while in reset (default mode is falling edge)
      pin_in = 8'hFF;
      repeat (3) @(negedge clk);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      get(I_PEND, v); check("R10 no pending from reset-time change", v, 8'h00);
      // R1 reset state
      for (int i = 0; i < 8; i++) begin
         get(3'(i), v); check("R1 register reset value", v, 8'h00);
      end
      check("R1 pin_oe after reset", pin_oe, 8'h00);
      check("R1 irq after reset", {{(W-1){1'b0}}, irq}, 8'h00);

      // R2 / R3 sweep of every direction mask
      for (int d = 0; d < 256; d++) begin
         lat = 8'(d) ^ 8'h5A;
         pv  = 8'(d * 37 + 11);
         put(I_DIR, 8'(d));
         put(I_DATA, lat);
         pin_in = pv;
         #1;
         check("R2 pin_oe follows direction", pin_oe, 8'(d));
         check("R2 pin_out follows latch", pin_out, lat);
         get(I_DATA, v);
         check("R3 data read mixes latch and pins", v, (8'(d) & lat) | (~8'(d) & pv));
         get(I_DIR, v);
         check("R3 direction readback", v, 8'(d));
      end
      put(I_DIR, 8'h00);

      // R4 / R5 / R6 sweep of every select combination; the two patterns
      // give every pin pair one of the four (previous, current) cases.
      pa = 8'h0F;
      pb = 8'h33;
      for (int c = 0; c < 8; c++) begin
         s0 = {W{c[0]}}; s1 = {W{c[1]}}; s2 = {W{c[2]}};
         tag = c[1] ? "R6" : (c[2] ? "R5" : "R4");
         pin_in = pa;
         put(I_S0, s0); put(I_S1, s1); put(I_S2, s2);
         repeat (2) @(negedge clk);
         put(I_PEND, 8'hFF);
         get(I_PEND, v);
         e1 = expect_hits(s0, s1, s2, pa, pa);
         check({tag, " pending after clear with steady pins"}, v, e1);
         pin_in = pb;
         @(negedge clk);
         get(I_PEND, v);
         e2 = e1 | expect_hits(s0, s1, s2, pa, pb);
         check({tag, " R11 pending one edge after change"}, v, e2);
         @(negedge clk);
         get(I_PEND, v);
         e3 = e2 | expect_hits(s0, s1, s2, pb, pb);
         check({tag, " pending with pins held"}, v, e3);
      end

      // R4 per-pin selection: odd pins rising, even pins falling
      put(I_S1, 8'h00); put(I_S2, 8'h00); put(I_S0, 8'hAA);
      pin_in = 8'h00;
      repeat (2) @(negedge clk);
      put(I_PEND, 8'hFF);
      pin_in = 8'hFF;
      @(negedge clk);
      get(I_PEND, v); check("R4 rising only on odd pins", v, 8'hAA);
      pin_in = 8'h00;
      @(negedge clk);
      get(I_PEND, v); check("R4 falling adds even pins", v, 8'hFF);

      // R8: falling change and clearing write in the same cycle
      put(I_S0, 8'h00);
      pin_in = 8'hFF;
      repeat (2) @(negedge clk);
      put(I_PEND, 8'hFF);
      get(I_PEND, v); check("R7 clear with steady pins", v, 8'h00);
      @(negedge clk);
      pin_in = 8'hF0;
      wr_en = 1'b1; reg_idx = I_PEND; wdata = 8'hFF;
      @(negedge clk);
      wr_en = 1'b0;
      get(I_PEND, v); check("R8 event beats clear", v, 8'h0F);

      // R7 partial clear and zero write
      put(I_PEND, 8'h05);
      get(I_PEND, v); check("R7 ones clear only their bits", v, 8'h0A);
      put(I_PEND, 8'h00);
      get(I_PEND, v); check("R7 zero write leaves pending", v, 8'h0A);
      check("R9 pending set while masked, irq low", {{(W-1){1'b0}}, irq}, 8'h00);

      // R9 sweep of every enable mask against pending 0x0A
      for (int e = 0; e < 256; e++) begin
         put(I_IEN, 8'(e));
         #1;
         check("R9 irq equals OR of pending and enable",
               {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(8'h0A & 8'(e))});
      end
      put(I_IEN, 8'h00);

      // R6 explicit re-set while level persists
      put(I_S0, 8'hFF); put(I_S1, 8'hFF);
      pin_in = 8'h3C;
      repeat (2) @(negedge clk);
      put(I_PEND, 8'hFF);
      get(I_PEND, v); check("R6 level high re-sets after clear", v, 8'h3C);
      pin_in = 8'h00;
      repeat (2) @(negedge clk);
      put(I_PEND, 8'hFF);
      get(I_PEND, v); check("R6 clear sticks once level gone", v, 8'h00);
      get(I_SPARE, v); check("R1 spare index reads zero", v, 8'h00);

      finish_run();
   end

endmodule